// File: doc/BRIEF.md
# Overflow-Trapping Integer Arithmetic Unit

This block is a 64-bit integer execution unit for a processor datapath. It adds, subtracts and multiplies two operands at either full (quadword, 64-bit) or half (longword, 32-bit) width. The trapping variant of each operation also reports signed overflow. A further operation returns the upper 64 bits of the unsigned 128-bit product. Add and subtract complete in one cycle. Multiplies are built from four 32x32 partial products, computed one per cycle, and take four cycles.

A caller drives a one-cycle `start` together with an opcode and two operands, then waits for `done`. On overflow, `ovf_trap` rises together with `done` and `err_code` carries the overflow code. The wrapped result is still presented in that cycle. Taking the exception and writing the register file are left to the surrounding pipeline.

Top module: `ovf_int_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `done`=0, `ovf_trap`=0, `err_code`=0 and `result`=0.
- R2: Opcodes 0 to 3 add and opcodes 4 to 7 subtract (`src_a` minus `src_b`). Codes 0/1 and 4/5 are quadword, codes 2/3 and 6/7 are longword, and the odd code of each pair is the trapping one. A quadword add or subtract presents the wrapped 64-bit result with `done` in the cycle after the edge that accepts `start`.
- R3: A trapping quadword add flags overflow when both operands share bit 63 and the result's bit 63 differs from it. A trapping quadword subtract flags overflow when the operands differ in bit 63 and the result's bit 63 differs from `src_a`'s bit 63.
- R4: A longword add or subtract uses the low 32 bits of the operands. Its 32-bit result is sign-extended from bit 31, and overflow is judged on bit 31 with the same sign rules as R3.
- R5: Opcodes 8 (plain) and 9 (trapping) multiply the low 32 bits of the operands as signed values. The result is the low 32 bits of the product sign-extended to 64. Overflow is flagged when the product is outside the signed 32-bit range.
- R6: Opcodes 10 (plain) and 11 (trapping) return the low 64 bits of the unsigned 128-bit product. Overflow is flagged when its upper 64 bits are nonzero.
- R7: Opcode 12 returns bits 127:64 of the unsigned 128-bit product of the operands and never flags overflow.
- R8: A multiply raises `done` four cycles after the edge that accepts its `start`. While a multiply is in progress, `start` is ignored and leaves no trace in any later output.
- R9: `ovf_trap` is only ever high together with `done` and only for trapping opcodes. `err_code` equals the parameter `OVF_CODE` while `ovf_trap` is high and is 0 at all other times.
- R10: `done` is high for exactly one cycle per accepted `start`. `result` keeps its value in every cycle without `done`.
- R11: Opcodes 13 to 15 are reserved. They complete like an add (R2 timing) with `result`=0 and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 4 | Operation code (see R2, R5 to R7, R11) |
| src_a | input | DATA_W | First operand (minuend for subtract) |
| src_b | input | DATA_W | Second operand |
| result | output | DATA_W | Result of the last completed operation |
| done | output | 1 | One-cycle completion strobe |
| ovf_trap | output | 1 | Arithmetic overflow indication, valid with `done` |
| err_code | output | ERR_W | Error code, `OVF_CODE` while `ovf_trap` is high |

## Verification
The bench builds the unit with `DATA_W`=64 and `ERR_W`=4, and sets `OVF_CODE` to 4'hA rather than the default. With that value, a code forced to a constant or a code copied from the trap bit would both show up as mismatches. At 64 bits the tests reach the sign-boundary operands of both widths and products whose upper halves need every carry out of the middle partial terms. The tests also reach starts issued during every cycle of a multiply.

// File: rtl/ovf_alu_pkg.sv
// Package: opcode encoding and decode helpers shared by the arithmetic unit
// and its checker. Assumes a 4-bit opcode; codes 13..15 are reserved.
package ovf_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADDQ  = 4'd0,  OP_ADDQV = 4'd1,  OP_ADDL  = 4'd2,  OP_ADDLV = 4'd3,
        OP_SUBQ  = 4'd4,  OP_SUBQV = 4'd5,  OP_SUBL  = 4'd6,  OP_SUBLV = 4'd7,
        OP_MULL  = 4'd8,  OP_MULLV = 4'd9,  OP_MULQ  = 4'd10, OP_MULQV = 4'd11,
        OP_MULHU = 4'd12
    } alu_op_e;

    // Multiply family: long/quad multiply and unsigned multiply-high
    function automatic logic op_is_mul(input logic [3:0] code);
        return (code >= 4'd8) && (code <= 4'd12);
    endfunction

    // Add/subtract family
    function automatic logic op_is_addsub(input logic [3:0] code);
        return !code[3];
    endfunction

    // Opcodes that may raise an overflow trap
    function automatic logic op_traps(input logic [3:0] code);
        return code[0] && (code <= 4'd11);
    endfunction

endpackage

// File: rtl/ovf_addsub.sv
// Module: ovf_addsub
// Combinational adder/subtractor with signed overflow detection at either
// the full width or the lower half width. Assumes DATA_W is even.
// Subtraction is done as a + ~b + 1, so one sign rule covers both.
module ovf_addsub #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic              narrow,
    output logic [DATA_W-1:0] res,
    output logic              ovf
);
    localparam int NW = DATA_W / 2;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] sum;
    logic              ovf_full;
    logic              ovf_half;

    // Sum of a and the (optionally inverted) second operand
    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + DATA_W'(sub);
    end

    // Overflow: operand signs agree and the sum sign departs from them
    always_comb begin
        ovf_full = (a[DATA_W-1] == b_eff[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
        ovf_half = (a[NW-1] == b_eff[NW-1]) && (sum[NW-1] != a[NW-1]);
    end

    // Width selection with sign extension of the half-width result
    always_comb begin
        if (narrow) begin
            res = {{NW{sum[NW-1]}}, sum[NW-1:0]};
            ovf = ovf_half;
        end else begin
            res = sum;
            ovf = ovf_full;
        end
    end
endmodule

// File: rtl/ovf_mul_iter.sv
// Module: ovf_mul_iter
// Iterative unsigned DATA_W x DATA_W multiplier. It accumulates the four
// half-width partial products lo*lo, lo*hi, hi*lo and hi*hi over four
// cycles into a 2*DATA_W accumulator. prod_nxt shows the final product
// while last is high. Assumes go is only acted on while idle.
module ovf_mul_iter #(
    parameter int DATA_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic [DATA_W-1:0]     a,
    input  logic [DATA_W-1:0]     b,
    output logic                  busy,
    output logic                  last,
    output logic [2*DATA_W-1:0]   prod_nxt
);
    localparam int HW = DATA_W / 2;
    localparam int PW = 2 * DATA_W;

    logic [DATA_W-1:0] a_q, b_q;
    logic [PW-1:0]     acc;
    logic [1:0]        step;
    logic              busy_q;
    logic [HW-1:0]     pa, pb;
    logic [DATA_W-1:0] part;
    logic [PW-1:0]     part_sh;

    // Select the operand halves and the weight of the current partial
    always_comb begin
        pa   = step[1] ? a_q[DATA_W-1:HW] : a_q[HW-1:0];
        pb   = step[0] ? b_q[DATA_W-1:HW] : b_q[HW-1:0];
        part = DATA_W'(pa) * DATA_W'(pb);
        case (step)
            2'd0:    part_sh = PW'(part);
            2'd3:    part_sh = PW'(part) << DATA_W;
            default: part_sh = PW'(part) << HW;
        endcase
        prod_nxt = acc + part_sh;
    end

    // Operand capture, accumulation and step sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            acc    <= '0;
            step   <= '0;
            busy_q <= 1'b0;
        end else if (!busy_q) begin
            if (go) begin
                a_q    <= a;
                b_q    <= b;
                acc    <= '0;
                step   <= '0;
                busy_q <= 1'b1;
            end
        end else begin
            acc  <= prod_nxt;
            step <= step + 2'd1;
            if (step == 2'd3) busy_q <= 1'b0;
        end
    end

    assign busy = busy_q;
    assign last = busy_q && (step == 2'd3);
endmodule

// File: rtl/ovf_int_alu.sv
// Module: ovf_int_alu (top)
// Integer add/subtract/multiply unit with per-width overflow trapping.
// Add/subtract results register on the accepting edge; multiplies finish
// four edges later. A start arriving while a multiply runs is dropped.
// Assumes DATA_W is even and OVF_CODE fits in ERR_W bits.
module ovf_int_alu
    import ovf_alu_pkg::*;
#(
    parameter int               DATA_W   = 64,
    parameter int               ERR_W    = 4,
    parameter logic [ERR_W-1:0] OVF_CODE = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] result,
    output logic              done,
    output logic              ovf_trap,
    output logic [ERR_W-1:0]  err_code
);
    localparam int HW = DATA_W / 2;
    localparam int PW = 2 * DATA_W;

    logic              mul_busy;
    logic              mul_last;
    logic [PW-1:0]     mul_prod;
    logic              accept;
    logic              mul_go;
    logic              narrow_mul;
    logic [DATA_W-1:0] mul_a, mul_b;
    logic [DATA_W-1:0] as_res;
    logic              as_ovf;
    logic [3:0]        op_q;
    logic [DATA_W-1:0] fin_res;
    logic              fin_ovf;
    logic [DATA_W-1:0] lo_prod;
    logic [DATA_W-1:0] lo_sext;

    // Request acceptance and multiplier operand preparation
    always_comb begin
        accept     = start && !mul_busy;
        mul_go     = accept && op_is_mul(op);
        narrow_mul = (op == OP_MULL) || (op == OP_MULLV);
        mul_a      = narrow_mul ? {{HW{src_a[HW-1]}}, src_a[HW-1:0]} : src_a;
        mul_b      = narrow_mul ? {{HW{src_b[HW-1]}}, src_b[HW-1:0]} : src_b;
    end

    ovf_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a      (src_a),
        .b      (src_b),
        .sub    (op[2]),
        .narrow (op[1]),
        .res    (as_res),
        .ovf    (as_ovf)
    );

    ovf_mul_iter #(.DATA_W(DATA_W)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (mul_go),
        .a        (mul_a),
        .b        (mul_b),
        .busy     (mul_busy),
        .last     (mul_last),
        .prod_nxt (mul_prod)
    );

    // Shape the finished product according to the latched opcode
    always_comb begin
        lo_prod = mul_prod[DATA_W-1:0];
        lo_sext = {{HW{lo_prod[HW-1]}}, lo_prod[HW-1:0]};
        case (op_q)
            OP_MULL, OP_MULLV: begin
                fin_res = lo_sext;
                fin_ovf = (lo_prod != lo_sext);
            end
            OP_MULQ, OP_MULQV: begin
                fin_res = lo_prod;
                fin_ovf = |mul_prod[PW-1:DATA_W];
            end
            default: begin
                fin_res = mul_prod[PW-1:DATA_W];
                fin_ovf = 1'b0;
            end
        endcase
    end

    // Latch the multiply opcode when the multiplier is started
    always_ff @(posedge clk) begin
        if (!rst_n)      op_q <= '0;
        else if (mul_go) op_q <= op;
    end

    // Output register: result, completion strobe and trap reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            done     <= 1'b0;
            ovf_trap <= 1'b0;
            err_code <= '0;
        end else begin
            done     <= 1'b0;
            ovf_trap <= 1'b0;
            err_code <= '0;
            if (mul_last) begin
                result   <= fin_res;
                done     <= 1'b1;
                ovf_trap <= fin_ovf && op_traps(op_q);
                err_code <= (fin_ovf && op_traps(op_q)) ? OVF_CODE : '0;
            end else if (accept && !op_is_mul(op)) begin
                result   <= op_is_addsub(op) ? as_res : '0;
                done     <= 1'b1;
                ovf_trap <= op_is_addsub(op) && op_traps(op) && as_ovf;
                err_code <= (op_is_addsub(op) && op_traps(op) && as_ovf) ? OVF_CODE : '0;
            end
        end
    end
endmodule

// File: rtl/ovf_int_alu_chk.sv
// Module: ovf_int_alu_chk
// Property checker for ovf_int_alu, attached with bind. It observes the
// ports and the multiplier's busy/last handshake.
module ovf_int_alu_chk
    import ovf_alu_pkg::*;
#(
    parameter int               DATA_W   = 64,
    parameter int               ERR_W    = 4,
    parameter logic [ERR_W-1:0] OVF_CODE = 4'h1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [3:0]        op,
    input logic [DATA_W-1:0] result,
    input logic              done,
    input logic              ovf_trap,
    input logic [ERR_W-1:0]  err_code,
    input logic              mul_busy,
    input logic              mul_last
);
    // R9: a trap is only reported alongside completion
    a_r9_trap_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> done);

    // R9: error code tracks the trap flag
    a_r9_err_code: assert property (@(posedge clk) disable iff (!rst_n)
        err_code == (ovf_trap ? OVF_CODE : '0));

    // R9: accepted non-trapping add/subtract never traps
    a_r9_no_trap_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mul_busy && op_is_addsub(op) && !op[0]) |=> !ovf_trap);

    // R2: accepted add/subtract completes on the next cycle
    a_r2_addsub_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mul_busy && op_is_addsub(op)) |=> done);

    // R8: no completion while the multiplier is mid-sequence
    a_r8_busy_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_busy && !mul_last) |=> !done);

    // R10: result holds whenever nothing completes
    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R11: reserved opcodes yield zero without a trap
    a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mul_busy && (op >= 4'd13)) |=> (done && !ovf_trap && result == '0));
endmodule

bind ovf_int_alu ovf_int_alu_chk #(
    .DATA_W   (DATA_W),
    .ERR_W    (ERR_W),
    .OVF_CODE (OVF_CODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .result   (result),
    .done     (done),
    .ovf_trap (ovf_trap),
    .err_code (err_code),
    .mul_busy (mul_busy),
    .mul_last (mul_last)
);

// File: tb/ovf_int_alu_test.sv
// Bench: behavioural reference model compared with the unit on every clock.
module ovf_int_alu_test;
    localparam int         DW   = 64;
    localparam int         EW   = 4;
    localparam logic [3:0] CODE = 4'hA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    op = '0;
    logic [DW-1:0] src_a = '0, src_b = '0;
    logic [DW-1:0] result;
    logic          done, ovf_trap;
    logic [EW-1:0] err_code;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    ovf_int_alu #(.DATA_W(DW), .ERR_W(EW), .OVF_CODE(CODE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b), .result(result), .done(done),
        .ovf_trap(ovf_trap), .err_code(err_code)
    );

    always #5 clk = ~clk;

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic string tag_of(input logic [3:0] o);
        if (o <= 4'd7) return o[1] ? "R4" : ((o == 4'd1 || o == 4'd5) ? "R3" : "R2");
        if (o <= 4'd9)  return "R5";
        if (o <= 4'd11) return "R6";
        if (o == 4'd12) return "R7";
        return "R11";
    endfunction

    // Behavioural expected value for each opcode
    task automatic ref_op(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y,
                          output logic [63:0] r, output logic v);
        logic signed [64:0]  w64;
        logic signed [32:0]  w32;
        logic signed [31:0]  x32, y32;
        longint              p;
        logic [127:0]        up;
        r = '0; v = 1'b0;
        x32 = x[31:0]; y32 = y[31:0];
        up  = {64'b0, x} * {64'b0, y};
        if (o <= 4'd7) begin
            if (!o[1]) begin
                w64 = o[2] ? ($signed({x[63], x}) - $signed({y[63], y}))
                           : ($signed({x[63], x}) + $signed({y[63], y}));
                r = w64[63:0]; v = o[0] && (w64[64] != w64[63]);
            end else begin
                w32 = o[2] ? ($signed({x32[31], x32}) - $signed({y32[31], y32}))
                           : ($signed({x32[31], x32}) + $signed({y32[31], y32}));
                r = sx32(w32[31:0]); v = o[0] && (w32[32] != w32[31]);
            end
        end else if (o <= 4'd9) begin
            p = longint'(x32) * longint'(y32);
            r = sx32(p[31:0]); v = o[0] && (p > 64'sd2147483647 || p < -64'sd2147483648);
        end else if (o <= 4'd11) begin
            r = up[63:0]; v = o[0] && (up[127:64] != 0);
        end else if (o == 4'd12) begin
            r = up[127:64];
        end
    endtask

    // Reference model state
    logic [63:0] exp_res = '0, pend_res = '0;
    logic        exp_done = 0, exp_trap = 0, pend_ovf = 0, live = 0;
    int          mbusy = 0;
    string       cur_tag = "R1", pend_tag = "R5";

    always @(posedge clk) begin
        logic [63:0] r; logic v;
        live <= 1'b1;
        if (!rst_n) begin
            exp_res = '0; exp_done = 0; exp_trap = 0; mbusy = 0; cur_tag = "R1";
        end else begin
            exp_done = 0; exp_trap = 0;
            if (mbusy > 0) begin
                mbusy--;
                if (mbusy == 0) begin
                    exp_done = 1; exp_res = pend_res; exp_trap = pend_ovf; cur_tag = pend_tag;
                end
            end else if (start) begin
                ref_op(op, src_a, src_b, r, v);
                if (op >= 4'd8 && op <= 4'd12) begin
                    mbusy = 4; pend_res = r; pend_ovf = v; pend_tag = tag_of(op);
                end else begin
                    exp_done = 1; exp_res = r; exp_trap = v; cur_tag = tag_of(op);
                end
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Compare on the falling edge, away from the active edge
    always @(negedge clk) begin
        if (live && !finished) begin
            chk(done == exp_done, (mbusy > 0 || cur_tag == "R1") ? (rst_n ? "R8" : "R1") : "R10",
                "done", 64'(done), 64'(exp_done));
            chk(result == exp_res, exp_done ? cur_tag : (rst_n ? "R10" : "R1"),
                "result", result, exp_res);
            chk(ovf_trap == exp_trap, exp_done ? cur_tag : "R9", "ovf_trap",
                64'(ovf_trap), 64'(exp_trap));
            chk(err_code == (exp_trap ? CODE : 4'h0), "R9", "err_code",
                64'(err_code), 64'(exp_trap ? CODE : 4'h0));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic issue(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y,
                         input int gap);
        @(negedge clk);
        start = 1'b1; op = o; src_a = x; src_b = y;
        @(negedge clk);
        start = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    function automatic logic [63:0] pick();
        case ($urandom_range(0, 5))
            0: return 64'h7FFF_FFFF_FFFF_FFFF;
            1: return 64'h8000_0000_0000_0000;
            2: return 64'h0000_0000_7FFF_FFFF;
            3: return {$urandom(), $urandom()} | 64'hFFFF_FFFF_0000_0000;
            4: return 64'(int'($urandom_range(0, 3)) - 2);
            default: return {$urandom(), $urandom()};
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);              // R1: reset values checked meanwhile
        rst_n = 1'b1;
        // R2/R3 quadword boundaries
        issue(4'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1);
        issue(4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1);
        issue(4'd1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1);
        issue(4'd5, 64'h8000_0000_0000_0000, 64'd1, 1);
        issue(4'd5, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1);
        issue(4'd5, 64'd5, 64'd7, 0);
        // R4 longword boundaries
        issue(4'd3, 64'h0000_0000_7FFF_FFFF, 64'd1, 0);
        issue(4'd7, 64'hFFFF_FFFF_8000_0000, 64'd1, 0);
        issue(4'd2, 64'h1234_5678_FFFF_FFFF, 64'd1, 1);
        // R5..R7 multiplies
        issue(4'd9, 64'h0001_0000, 64'h0001_0000, 5);
        issue(4'd9, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 5);
        issue(4'd8, 64'h7FFF_FFFF, 64'h7FFF_FFFF, 5);
        issue(4'd11, 64'h1_0000_0000, 64'h1_0000_0000, 5);
        issue(4'd11, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 5);
        issue(4'd12, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 5);
        // R8: starts during a multiply are dropped
        issue(4'd10, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 0);
        issue(4'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0);
        issue(4'd13, 64'd1, 64'd1, 0);
        issue(4'd0, 64'd3, 64'd4, 3);
        // R11 reserved codes
        issue(4'd15, 64'd9, 64'd9, 1);
        for (int i = 0; i < 600; i++)
            issue(4'($urandom_range(0, 15)), pick(), pick(), $urandom_range(0, 4));
        repeat (8) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule